// File: doc/BRIEF.md
# Spread-Spectrum Fractional Divide Ratio Controller

This block produces, once per reference clock cycle, the integer ratio that the feedback divider of a fractional-N PLL should use next. From a nominal ratio, made of an integer part and a 24-bit fractional part, it subtracts a triangular frequency deviation so that the output clock sweeps downward from its nominal value and back. The reduced spectral peak that results lowers EMI. A third-order cascade of three first-order accumulators (the MASH 1-1-1 form) then turns the fractional remainder into a dithered integer offset. Over time, the integer ratios it emits average to the exact requested value.

The sweep depth and rate are set at the block's inputs. The ramp length sets the rate: `half_len` is the number of reference cycles from the nominal point to the deepest point, and the full period is twice that. The ramp slope sets the depth: `ramp_step` is the deviation added or removed each cycle, in units of 2^-24 of one divide step. With a 25 MHz reference and a nominal ratio of 60, which gives a 1.5 GHz output, a ramp length of 379 gives a modulation rate of about 33 kHz and a length of 417 gives about 30 kHz. A slope of 13280 then gives a peak deviation just under 0.5 % of the ratio. The analog loop, the oscillator, the phase detector and the divider counter are outside this block.

Top module: `ssc_divctl`

## Requirements
- R1: While reset is high, `div_o` is 0. At the first edge after reset is released, the sweep is at zero deviation and heading downward, and all accumulators and delay stages are clear. With a zero fractional part, the first output is therefore exactly `nom_int`.
- R2: With spread disabled and a zero fractional part held since reset, `div_o` equals `nom_int` on every cycle.
- R3: With spread disabled, the sum of `div_o` over any window of W cycles is within 6 of W·(`nom_int` + `nom_frac`/2^24).
- R4: Each `div_o` equals the integer part of the effective ratio from the previous cycle plus an offset in the range −3 to +4 inclusive.
- R5: With spread enabled, the deviation changes by exactly `ramp_step` each cycle. Starting from zero, it grows for `half_len` cycles, then shrinks for `half_len` cycles back to zero, then repeats.
- R6: The effective ratio never exceeds the nominal ratio. Over one full period of 2·`half_len` cycles that starts at zero deviation, the sum of `div_o` is within 6 of 2·`half_len`·nominal − `ramp_step`·`half_len`²/2^24.
- R7: The modulation rate is set only by `half_len`: changing it, with spread off in between, changes the period to twice the new value.
- R8: While spread is disabled, the deviation returns to zero. After re-enabling, the sweep restarts from zero heading downward.
- R9: The offset is c1 + (c2 − c2 delayed one cycle) + (c3 − 2·c3 delayed one cycle + c3 delayed two cycles), where c1, c2 and c3 are the carries of the three cascaded accumulators. Each stage accumulates the previous stage's new sum. Consequently, over any window of W cycles, the sum of `div_o` is within 6 of the sum of the effective ratios.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| spread_en | input | 1 | Enables the triangular down-spread sweep |
| half_len | input | CNT_W | Reference cycles per ramp (half a modulation period), at least 1 |
| ramp_step | input | FRAC_W | Deviation change per cycle, units of 2^-24 |
| nom_int | input | INT_W | Integer part of the nominal ratio, at least 4 |
| nom_frac | input | FRAC_W | Fractional part of the nominal ratio |
| div_o | output | INT_W | Divide ratio for the next reference cycle |

## Verification
The bench builds the block with its default widths: an 8-bit integer part, a 24-bit fraction and a 10-bit ramp counter. These defaults let it drive the nominal case of 60 with a ramp length of 379 and a slope of 13280, and also the 30 kHz setting of 417, which is reached through the same counter width. Because the fraction uses its full 24 bits, the window-sum tolerance of R3, R6 and R9 is tight enough to expose a single misplaced carry or delay. The sweep stays well inside the ratio, so random nominal ratios between 20 and 200 with random slopes never underflow the effective word.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
package ssc_pkg;
    localparam int MASH_ORDER = 3;
    localparam int OFS_W      = 4;

    typedef enum logic {
        SWEEP_DOWN = 1'b0,
        SWEEP_UP   = 1'b1
    } sweep_dir_e;
endpackage

// File: rtl/tri_sweep.sv
`timescale 1ns/1ps
module tri_sweep
    import ssc_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int STEP_W = 24,
    parameter int DEV_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CNT_W-1:0]  half_len,
    input  logic [STEP_W-1:0] step,
    output logic [DEV_W-1:0]  dev_o
);
    typedef struct packed {
        sweep_dir_e       dir;
        logic [CNT_W-1:0] pos;
        logic [DEV_W-1:0] dev;
    } sweep_t;

    sweep_t st_d, st_q;
    logic [CNT_W-1:0] pos_inc, pos_dec;

    always_comb begin
        st_d    = st_q;
        pos_inc = st_q.pos + CNT_W'(1);
        pos_dec = st_q.pos - CNT_W'(1);
        if (!en) begin
            st_d.dir = SWEEP_DOWN;
            st_d.pos = '0;
            st_d.dev = '0;
        end else if (st_q.dir == SWEEP_DOWN) begin
            st_d.pos = pos_inc;
            st_d.dev = st_q.dev + DEV_W'(step);
            if (pos_inc == half_len) st_d.dir = SWEEP_UP;
        end else begin
            st_d.pos = pos_dec;
            st_d.dev = st_q.dev - DEV_W'(step);
            if (pos_dec == '0) st_d.dir = SWEEP_DOWN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.dir <= SWEEP_DOWN;
            st_q.pos <= '0;
            st_q.dev <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dev_o = st_q.dev;
endmodule

// File: rtl/mash_stage.sv
`timescale 1ns/1ps
module mash_stage #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_w,
    output logic         carry_o,
    output logic [W-1:0] sum_o
);
    logic [W:0]   full_sum;
    logic [W-1:0] acc_d, acc_q;

    always_comb begin
        full_sum = {1'b0, acc_q} + {1'b0, in_w};
        acc_d    = full_sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    assign carry_o = full_sum[W];
    assign sum_o   = acc_d;
endmodule

// File: rtl/mash_combine.sv
`timescale 1ns/1ps
module mash_combine
    import ssc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [MASH_ORDER-1:0]   carry_i,
    output logic signed [OFS_W-1:0] ofs_o
);
    typedef struct packed {
        logic c2_z1;
        logic c3_z1;
        logic c3_z2;
    } dly_t;

    dly_t dl_d, dl_q;

    always_comb begin
        dl_d.c2_z1 = carry_i[1];
        dl_d.c3_z1 = carry_i[2];
        dl_d.c3_z2 = dl_q.c3_z1;
        ofs_o = $signed({3'b000, carry_i[0]})
              + $signed({3'b000, carry_i[1]}) - $signed({3'b000, dl_q.c2_z1})
              + $signed({3'b000, carry_i[2]}) - $signed({2'b00, dl_q.c3_z1, 1'b0})
              + $signed({3'b000, dl_q.c3_z2});
    end

    always_ff @(posedge clk) begin
        if (rst) dl_q <= '0;
        else     dl_q <= dl_d;
    end
endmodule

// File: rtl/ssc_divctl.sv
`timescale 1ns/1ps
module ssc_divctl
    import ssc_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 24,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spread_en,
    input  logic [CNT_W-1:0]  half_len,
    input  logic [FRAC_W-1:0] ramp_step,
    input  logic [INT_W-1:0]  nom_int,
    input  logic [FRAC_W-1:0] nom_frac,
    output logic [INT_W-1:0]  div_o
);
    localparam int TOT_W = INT_W + FRAC_W;

    logic [TOT_W-1:0]        dev;
    logic [TOT_W-1:0]        eff_word;
    logic [INT_W-1:0]        eff_int;
    logic [FRAC_W-1:0]       st_in [MASH_ORDER+1];
    logic [MASH_ORDER-1:0]   carry;
    logic signed [OFS_W-1:0] ofs;
    logic [INT_W-1:0]        div_d, div_q;

    tri_sweep #(.CNT_W(CNT_W), .STEP_W(FRAC_W), .DEV_W(TOT_W)) u_sweep (
        .clk(clk), .rst(rst), .en(spread_en),
        .half_len(half_len), .step(ramp_step), .dev_o(dev)
    );

    always_comb begin
        eff_word = {nom_int, nom_frac} - dev;
        eff_int  = eff_word[TOT_W-1:FRAC_W];
        st_in[0] = eff_word[FRAC_W-1:0];
    end

    for (genvar k = 0; k < MASH_ORDER; k++) begin : g_stage
        mash_stage #(.W(FRAC_W)) u_stage (
            .clk(clk), .rst(rst), .in_w(st_in[k]),
            .carry_o(carry[k]), .sum_o(st_in[k+1])
        );
    end

    mash_combine u_comb (.clk(clk), .rst(rst), .carry_i(carry), .ofs_o(ofs));

    always_comb begin
        div_d = eff_int + {{(INT_W-OFS_W){ofs[OFS_W-1]}}, ofs};
    end

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_d;
    end

    assign div_o = div_q;
endmodule

// File: rtl/ssc_divctl_chk.sv
`timescale 1ns/1ps
module ssc_divctl_chk #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 24,
    parameter int TOT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              spread_en,
    input logic [FRAC_W-1:0] ramp_step,
    input logic [INT_W-1:0]  nom_int,
    input logic [FRAC_W-1:0] nom_frac,
    input logic [INT_W-1:0]  div_o,
    input logic [TOT_W-1:0]  eff_word,
    input logic [TOT_W-1:0]  dev
);
    logic past_ok, clean_q;
    logic signed [INT_W+1:0] diff;

    always_ff @(posedge clk) begin
        past_ok <= !rst;
        clean_q <= rst ? 1'b1 : (clean_q && !spread_en && (nom_frac == '0));
    end

    assign diff = $signed({2'b00, div_o}) - $signed({2'b00, eff_word[TOT_W-1:FRAC_W]});

    // R4: offset stays in -3..+4
    p_offset_range_r4: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (($signed({2'b00, div_o}) - $past($signed({2'b00, eff_word[TOT_W-1:FRAC_W]}))) >= -3 &&
                     ($signed({2'b00, div_o}) - $past($signed({2'b00, eff_word[TOT_W-1:FRAC_W]}))) <= 4));

    // R2: clean nominal operation gives constant ratio
    p_const_nominal_r2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && clean_q) |-> (div_o == $past(nom_int)));

    // R6: down-spread only
    p_down_only_r6: assert property (@(posedge clk) disable iff (rst)
        eff_word <= {nom_int, nom_frac});

    // R5: deviation moves by exactly one step per cycle
    p_ramp_step_r5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(spread_en)) |->
            ((dev - $past(dev)) == TOT_W'(ramp_step) || ($past(dev) - dev) == TOT_W'(ramp_step)));

    // R8: disabled spread returns deviation to zero
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(spread_en)) |-> (dev == '0));
endmodule

bind ssc_divctl ssc_divctl_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W), .TOT_W(TOT_W)) u_chk (
    .clk(clk), .rst(rst), .spread_en(spread_en), .ramp_step(ramp_step),
    .nom_int(nom_int), .nom_frac(nom_frac), .div_o(div_o),
    .eff_word(eff_word), .dev(dev)
);

// File: tb/tb_ssc_divctl.sv
`timescale 1ns/1ps
module tb_ssc_divctl;
    localparam int INT_W = 8, FRAC_W = 24, CNT_W = 10;
    localparam longint ONE = 64'd1 << FRAC_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spread_en = 1'b0;
    logic [CNT_W-1:0]  half_len = 10'd379;
    logic [FRAC_W-1:0] ramp_step = 24'd13280;
    logic [INT_W-1:0]  nom_int = 8'd60;
    logic [FRAC_W-1:0] nom_frac = '0;
    logic [INT_W-1:0]  div_o;

    int checks = 0, errors = 0;
    int m_pos = 0;
    bit m_down = 1'b1;
    longint sum_div, sum_eff;
    int range_bad, const_bad;

    always #4 clk = ~clk;

    ssc_divctl #(.INT_W(INT_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .spread_en(spread_en), .half_len(half_len),
        .ramp_step(ramp_step), .nom_int(nom_int), .nom_frac(nom_frac), .div_o(div_o)
    );

    function automatic longint nom_word();
        return longint'(nom_int) * ONE + longint'(nom_frac);
    endfunction

    function automatic longint eff_now();
        return nom_word() - (spread_en ? longint'(m_pos) * longint'(ramp_step) : 64'd0);
    endfunction

    function automatic longint period_sum();
        longint h = longint'(half_len);
        return 2 * h * nom_word() - longint'(ramp_step) * h * h;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        m_pos = 0; m_down = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(int n);
        sum_div = 0; sum_eff = 0; range_bad = 0; const_bad = 0;
        for (int i = 0; i < n; i++) begin
            longint e = eff_now();
            longint d;
            @(negedge clk);
            d = longint'(div_o) - (e >>> FRAC_W);
            if (d < -3 || d > 4) range_bad++;
            if (div_o != nom_int) const_bad++;
            sum_div += longint'(div_o) * ONE;
            sum_eff += e;
            if (spread_en) begin
                if (m_down) begin m_pos++; if (m_pos == int'(half_len)) m_down = 1'b0; end
                else begin m_pos--; if (m_pos == 0) m_down = 1'b1; end
            end else begin
                m_pos = 0; m_down = 1'b1;
            end
        end
    endtask

    function automatic longint absl(longint v);
        return (v < 0) ? -v : v;
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state and first output
        repeat (2) @(negedge clk);
        chk(div_o == 0, "R1 reset output", div_o, 0);
        do_reset();
        run(1);
        chk(div_o == 8'd60, "R1 first output", div_o, 60);
        // R2: constant nominal ratio
        run(200);
        chk(const_bad == 0, "R2 constant ratio", const_bad, 0);

        // R5 / R6 / R9 / R4: nominal 33 kHz sweep
        do_reset();
        spread_en = 1'b1;
        run(379);
        chk(absl(sum_div - sum_eff) <= 6 * ONE, "R5 falling ramp sum", sum_div / ONE, sum_eff / ONE);
        chk(range_bad == 0, "R4 offset range", range_bad, 0);
        do_reset();
        run(758);
        chk(absl(sum_div - period_sum()) <= 6 * ONE, "R6 period average", sum_div / ONE, period_sum() / ONE);
        chk(absl(sum_div - sum_eff) <= 6 * ONE, "R9 shaped sum", sum_div / ONE, sum_eff / ONE);
        chk(range_bad == 0, "R4 offset range sweep", range_bad, 0);
        run(758);
        chk(absl(sum_div - period_sum()) <= 6 * ONE, "R5 second period", sum_div / ONE, period_sum() / ONE);

        // R7: 30 kHz setting
        spread_en = 1'b0; run(4);
        half_len = 10'd417; ramp_step = 24'd12070;
        spread_en = 1'b1;
        run(834);
        chk(absl(sum_div - period_sum()) <= 6 * ONE, "R7 period at 417", sum_div / ONE, period_sum() / ONE);

        // R8: disable mid-sweep then restart
        run(200);
        spread_en = 1'b0;
        run(10);
        chk(absl(sum_div - 10 * nom_word()) <= 6 * ONE, "R8 idle returns nominal", sum_div / ONE, 10 * nom_word() / ONE);
        spread_en = 1'b1;
        run(834);
        chk(absl(sum_div - period_sum()) <= 6 * ONE, "R8 restart from zero", sum_div / ONE, period_sum() / ONE);

        // R3: random fractional parts, spread off
        for (int t = 0; t < 4; t++) begin
            spread_en = 1'b0;
            nom_int = 8'(20 + $urandom_range(0, 180));
            nom_frac = (t == 0) ? 24'hFFFFFF : 24'($urandom);
            do_reset();
            run(600);
            chk(absl(sum_div - 600 * nom_word()) <= 6 * ONE, "R3 average ratio", sum_div / ONE, 600 * nom_word() / ONE);
            chk(range_bad == 0, "R4 offset range random", range_bad, 0);
        end

        // R6 / R9: random sweeps
        for (int t = 0; t < 3; t++) begin
            spread_en = 1'b0;
            nom_int = 8'(20 + $urandom_range(0, 180));
            nom_frac = 24'($urandom);
            half_len = 10'($urandom_range(379, 417));
            ramp_step = 24'($urandom_range(1000, 15000));
            do_reset();
            spread_en = 1'b1;
            run(2 * int'(half_len));
            chk(absl(sum_div - period_sum()) <= 6 * ONE, "R6 random period", sum_div / ONE, period_sum() / ONE);
            chk(absl(sum_div - sum_eff) <= 6 * ONE, "R9 random shaped sum", sum_div / ONE, sum_eff / ONE);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule